// File: doc/BRIEF.md
# Boot Watchdog with Alternate Boot-Device Toggle

This block supervises each board power-up and waits for the host to report that its boot finished. A seconds strobe advances a timer that starts when the board-powered input rises. If the host pulses its boot-done acknowledge before the limit, the timer stops for that boot. If the limit is reached first, the block raises a one-cycle power-cycle request. It can also flip a persistent select bit that chooses between the primary boot device and the alternate one.

Two operating styles are supported, chosen at each power-up by a mode input. In the legacy style, the enable input decides at power-up whether the watchdog runs at all. In the newer style, the watchdog runs on every boot, and the enable only decides whether an expiry flips the boot device. A separate manual request, coming from a pushbutton burst detector, flips the boot device and asks for a power cycle straight away. A 4-bit cause code records why the block last cycled the board, and a sticky flag reports that a watchdog timeout has happened.

Top module: `boot_watchdog`

## Requirements
- R1: After reset, boot_sel is 0 (primary), pwr_cycle_req is 0, reset_cause is 0 and timeout_flag is 0.
- R2: On a rising edge of board_pwr, the watchdog arms. In legacy mode (mode_sel=0 at that edge), it arms only if wd_enable is 1. In new mode (mode_sel=1), it always arms. The mode is held from that edge until the next power-up.
- R3: If armed and no acknowledge arrives, the TIMEOUT_S-th sec_tick sampled after power-up produces pwr_cycle_req high for exactly one cycle, two clock edges after that tick is sampled.
- R4: A boot_ack pulse before expiry stops the watchdog for the current boot. No request follows, however many ticks arrive later.
- R5: After an expiry or an acknowledge, the timer stays idle until board_pwr falls and rises again. It then re-arms under the R2 rule.
- R6: On expiry, boot_sel flips in legacy mode. In new mode it flips only if wd_enable is 1 at expiry. The power-cycle request is issued in both cases.
- R7: An expiry sets reset_cause to 7 and sets timeout_flag. timeout_flag stays set until the block is reset.
- R8: A rising edge on manual_toggle while board_pwr is high does three things: it flips boot_sel, issues a one-cycle pwr_cycle_req, and sets reset_cause to 8. While board_pwr is low, the edge is ignored.
- R9: A fall of board_pwr with no request of the block outstanding since the last power-up clears reset_cause to 0. After a request of the block, the code is kept across that power cycle.
- R10: If an expiry and a manual edge land in the same cycle, the expiry wins: boot_sel flips at most once and reset_cause becomes 7.
- R11: Ticks while board_pwr is low are not counted. A power drop during a count restarts the count from zero at the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sec_tick | input | 1 | One-cycle strobe once per second |
| board_pwr | input | 1 | High while the board's primary power is on |
| mode_sel | input | 1 | 0 = legacy style, 1 = new style; sampled at power-up |
| wd_enable | input | 1 | Watchdog / boot-toggle enable |
| boot_ack | input | 1 | Write-one pulse from the host: boot completed |
| manual_toggle | input | 1 | Request from the pushbutton burst detector (edge used) |
| boot_sel | output | 1 | Persistent boot device select, 0 primary, 1 alternate |
| pwr_cycle_req | output | 1 | One-cycle request to power-cycle the board |
| reset_cause | output | 4 | Last cause code: 0 external, 7 watchdog, 8 manual |
| timeout_flag | output | 1 | Sticky watchdog-timeout status |

## Verification
The bench builds the block with TIMEOUT_S set to 5 and keeps the default cause codes. Every expiry therefore sits five driven ticks after power-up, which makes exact tick boundaries, early acknowledges and mid-count power drops quick to reach. A single instance covers both operating styles, because the mode is taken from a pin at each power-up. This lets legacy and new-mode boots alternate while the persistent select bit and the cause code carry over between them.

// File: rtl/boot_wd_pkg.sv
package boot_wd_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1
  } wd_state_e;

  localparam int CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_WDT    = 4'd7;
  localparam logic [CAUSE_W-1:0] CAUSE_MANUAL = 4'd8;

endpackage

// File: rtl/bwd_pwr_track.sv
module bwd_pwr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic board_pwr,
  input  logic mode_sel,
  input  logic manual_toggle,
  output logic pwr_rise,
  output logic pwr_fall,
  output logic mode_q,
  output logic manual_hit
);

  logic pwr_q;
  logic man_q;
  logic mode_d;

  assign pwr_rise   = board_pwr & ~pwr_q;
  assign pwr_fall   = ~board_pwr & pwr_q;
  assign manual_hit = manual_toggle & ~man_q & board_pwr;

  always_comb begin
    mode_d = mode_q;
    if (pwr_rise) mode_d = mode_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      man_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      pwr_q  <= board_pwr;
      man_q  <= manual_toggle;
      mode_q <= mode_d;
    end
  end

  AST_MANUAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !board_pwr |-> !manual_hit) else $error("manual accepted while off"); // R8

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import boot_wd_pkg::*;
#(
  parameter int TIMEOUT_S = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic board_pwr,
  input  logic pwr_rise,
  input  logic arm_ok,
  input  logic boot_ack,
  output logic expire
);

  localparam int CW = $clog2(TIMEOUT_S + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_S - 1);

  wd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    exp_d   = 1'b0;
    if (pwr_rise) begin
      state_d = arm_ok ? WD_RUN : WD_IDLE;
      cnt_d   = '0;
    end else if (!board_pwr) begin
      state_d = WD_IDLE;
      cnt_d   = '0;
    end else if (state_q == WD_RUN) begin
      if (boot_ack) begin
        state_d = WD_IDLE;
      end else if (sec_tick) begin
        if (cnt_q == LAST) begin
          exp_d   = 1'b1;
          state_d = WD_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      expire  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      expire  <= exp_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("count past limit"); // R3

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !board_pwr |=> (state_q == WD_IDLE && cnt_q == '0)) else $error("runs while off"); // R11

  AST_ACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && boot_ack && board_pwr && !pwr_rise) |=> (state_q == WD_IDLE && !expire))
    else $error("ack did not stop"); // R4

  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire) else $error("expire longer than a cycle"); // R3

endmodule

// File: rtl/bwd_select.sv
module bwd_select
  import boot_wd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire,
  input  logic               manual_hit,
  input  logic               toggle_ok,
  input  logic               pwr_rise,
  input  logic               pwr_fall,
  output logic               boot_sel,
  output logic               pwr_cycle_req,
  output logic [CAUSE_W-1:0] reset_cause,
  output logic               timeout_flag
);

  logic               sel_d, req_d, flag_d, pend_q, pend_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    sel_d   = boot_sel;
    req_d   = 1'b0;
    cause_d = reset_cause;
    flag_d  = timeout_flag;
    pend_d  = pend_q;
    if (pwr_rise) pend_d = 1'b0;
    if (pwr_fall && !pend_q) cause_d = CAUSE_NONE;
    if (expire) begin
      req_d   = 1'b1;
      cause_d = CAUSE_WDT;
      flag_d  = 1'b1;
      pend_d  = 1'b1;
      if (toggle_ok) sel_d = ~boot_sel;
    end else if (manual_hit) begin
      req_d   = 1'b1;
      cause_d = CAUSE_MANUAL;
      pend_d  = 1'b1;
      sel_d   = ~boot_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_sel      <= 1'b0;
      pwr_cycle_req <= 1'b0;
      reset_cause   <= CAUSE_NONE;
      timeout_flag  <= 1'b0;
      pend_q        <= 1'b0;
    end else begin
      boot_sel      <= sel_d;
      pwr_cycle_req <= req_d;
      reset_cause   <= cause_d;
      timeout_flag  <= flag_d;
      pend_q        <= pend_d;
    end
  end

  AST_EXPIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (reset_cause == CAUSE_WDT && timeout_flag && pwr_cycle_req))
    else $error("expiry not recorded"); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag) else $error("flag dropped"); // R7

  AST_MANUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_hit && !expire) |=> (pwr_cycle_req && reset_cause == CAUSE_MANUAL))
    else $error("manual not served"); // R8

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(boot_sel) |-> pwr_cycle_req) else $error("select moved silently"); // R6

endmodule

// File: rtl/boot_watchdog.sv
module boot_watchdog
  import boot_wd_pkg::*;
#(
  parameter int TIMEOUT_S = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               board_pwr,
  input  logic               mode_sel,
  input  logic               wd_enable,
  input  logic               boot_ack,
  input  logic               manual_toggle,
  output logic               boot_sel,
  output logic               pwr_cycle_req,
  output logic [CAUSE_W-1:0] reset_cause,
  output logic               timeout_flag
);

  logic pwr_rise, pwr_fall, mode_q, manual_hit, expire;
  logic arm_ok, toggle_ok;

  assign arm_ok    = mode_sel | wd_enable;
  assign toggle_ok = mode_q ? wd_enable : 1'b1;

  bwd_pwr_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .board_pwr     (board_pwr),
    .mode_sel      (mode_sel),
    .manual_toggle (manual_toggle),
    .pwr_rise      (pwr_rise),
    .pwr_fall      (pwr_fall),
    .mode_q        (mode_q),
    .manual_hit    (manual_hit)
  );

  bwd_timer #(.TIMEOUT_S(TIMEOUT_S)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .board_pwr (board_pwr),
    .pwr_rise  (pwr_rise),
    .arm_ok    (arm_ok),
    .boot_ack  (boot_ack),
    .expire    (expire)
  );

  bwd_select u_select (
    .clk           (clk),
    .rst_n         (rst_n),
    .expire        (expire),
    .manual_hit    (manual_hit),
    .toggle_ok     (toggle_ok),
    .pwr_rise      (pwr_rise),
    .pwr_fall      (pwr_fall),
    .boot_sel      (boot_sel),
    .pwr_cycle_req (pwr_cycle_req),
    .reset_cause   (reset_cause),
    .timeout_flag  (timeout_flag)
  );

  AST_REQ_NEEDS_PWR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_req |-> $past(expire || manual_hit)) else $error("stray request"); // R3

endmodule

// File: tb/tb_boot_watchdog.sv
module tb_boot_watchdog;

  localparam int TO = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick, board_pwr, mode_sel, wd_enable, boot_ack, manual_toggle;
  logic       boot_sel, pwr_cycle_req, timeout_flag;
  logic [3:0] reset_cause;

  int checks = 0;
  int failures = 0;
  logic exp_sel = 1'b0;

  always #5 clk = ~clk;

  boot_watchdog #(.TIMEOUT_S(TO)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .board_pwr(board_pwr),
    .mode_sel(mode_sel), .wd_enable(wd_enable), .boot_ack(boot_ack),
    .manual_toggle(manual_toggle), .boot_sel(boot_sel),
    .pwr_cycle_req(pwr_cycle_req), .reset_cause(reset_cause),
    .timeout_flag(timeout_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  // n ticks, checking no request appears during or one cycle after them
  task automatic quiet_ticks(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (pwr_cycle_req) seen++;
    end
    @(negedge clk);
    if (pwr_cycle_req) seen++;
    chk(req, seen, 0);
  endtask

  task automatic power_up(input logic m, input logic en);
    @(negedge clk) begin mode_sel = m; wd_enable = en; board_pwr = 1'b1; end
    @(negedge clk);
  endtask

  task automatic power_down();
    @(negedge clk) board_pwr = 1'b0;
    @(negedge clk);
  endtask

  // final tick that should expire; checks pulse and record
  task automatic expect_expiry(input logic flips, input string req);
    tick();
    @(negedge clk);
    if (flips) exp_sel = ~exp_sel;
    chk({req, " req pulse"}, pwr_cycle_req, 1);
    chk({req, " boot_sel"}, boot_sel, exp_sel);
    chk("R7 cause 7", reset_cause, 7);
    chk("R7 flag", timeout_flag, 1);
    @(negedge clk);
    chk("R3 single cycle", pwr_cycle_req, 0);
  endtask

  task automatic t_reset();
    chk("R1 boot_sel", boot_sel, 0);
    chk("R1 req", pwr_cycle_req, 0);
    chk("R1 cause", reset_cause, 0);
    chk("R1 flag", timeout_flag, 0);
  endtask

  task automatic t_legacy_expire();
    power_up(1'b0, 1'b1);
    quiet_ticks(TO - 1, "R3 no early req");
    expect_expiry(1'b1, "R3/R6 legacy");
    quiet_ticks(TO + 2, "R5 idle after expiry");
    power_down();
    chk("R9 cause kept after own request", reset_cause, 7);
  endtask

  task automatic t_legacy_disabled();
    power_up(1'b0, 1'b0);
    quiet_ticks(2 * TO, "R2 legacy disabled not armed");
    chk("R2 sel unchanged", boot_sel, exp_sel);
    power_down();
    chk("R9 cause cleared on external drop", reset_cause, 0);
  endtask

  task automatic t_ack();
    power_up(1'b0, 1'b1);
    quiet_ticks(TO - 2, "R4 before ack");
    @(negedge clk) boot_ack = 1'b1;
    @(negedge clk) boot_ack = 1'b0;
    quiet_ticks(2 * TO, "R4 ack stops watchdog");
    chk("R4 sel unchanged", boot_sel, exp_sel);
    power_down();
  endtask

  task automatic t_new_modes();
    power_up(1'b1, 1'b0);
    quiet_ticks(TO - 1, "R2 new mode armed");
    expect_expiry(1'b0, "R6 new mode no toggle");
    power_down();
    power_up(1'b1, 1'b1);
    quiet_ticks(TO - 1, "R5 re-armed");
    expect_expiry(1'b1, "R6 new mode toggle");
    power_down();
  endtask

  task automatic t_drop();
    power_up(1'b1, 1'b1);
    quiet_ticks(TO - 2, "R11 before drop");
    power_down();
    quiet_ticks(TO, "R11 ticks while off");
    power_up(1'b1, 1'b1);
    quiet_ticks(TO - 1, "R11 restart from zero");
    expect_expiry(1'b1, "R11 full count");
    power_down();
  endtask

  task automatic t_manual();
    power_up(1'b0, 1'b0);
    @(negedge clk) manual_toggle = 1'b1;
    @(negedge clk) manual_toggle = 1'b0;
    exp_sel = ~exp_sel;
    chk("R8 req", pwr_cycle_req, 1);
    chk("R8 sel", boot_sel, exp_sel);
    chk("R8 cause 8", reset_cause, 8);
    @(negedge clk);
    chk("R8 single cycle", pwr_cycle_req, 0);
    power_down();
    @(negedge clk) manual_toggle = 1'b1;
    @(negedge clk) manual_toggle = 1'b0;
    chk("R8 ignored off req", pwr_cycle_req, 0);
    @(negedge clk);
    chk("R8 ignored off sel", boot_sel, exp_sel);
    chk("R8 ignored off cause", reset_cause, 8);
  endtask

  task automatic t_collide();
    power_up(1'b0, 1'b1);
    quiet_ticks(TO - 1, "R10 prefix");
    tick();
    manual_toggle = 1'b1;
    @(negedge clk) manual_toggle = 1'b0;
    exp_sel = ~exp_sel;
    chk("R10 req", pwr_cycle_req, 1);
    chk("R10 single flip", boot_sel, exp_sel);
    chk("R10 cause 7", reset_cause, 7);
    power_down();
    chk("R7 flag sticky", timeout_flag, 1);
  endtask

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; board_pwr = 1'b0; mode_sel = 1'b0;
    wd_enable = 1'b0; boot_ack = 1'b0; manual_toggle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy_expire();
    t_legacy_disabled();
    t_ack();
    t_new_modes();
    t_drop();
    t_manual();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule